// File: doc/BRIEF.md
# Trigger Card Register Decoder with Command Lockout

This block sits behind the bus slave port of a calorimeter trigger card. Every bus access carries a 24-bit address. The top five address bits must equal the board number set on front-panel switches, or the card ignores the access. A claimed access is steered in one of two directions. The first is one of 28 memory blocks, each reached through a one-hot select strobe and a 13-bit word address. The second is a small bank of control registers: the command word, the two pedestal DAC settings, the eight analog delay settings and two read-only monitor ports. The memories, DACs and delay lines are outside the block. The block drives their select and load strobes and holds the register values that feed them.

The command word sets gain, the backplane output port, overflow blocking and a function code. The function code decides which memory accesses are allowed. Two function codes lock the card. While the card is locked, any access to the board, whatever its address, reads or writes the command word. Software leaves the locked state by writing a new function code. A command write takes effect only when its upper and lower 16-bit halves carry the same value, which guards against a corrupted write.

Each access is a single-cycle request. The block answers one clock later with an acknowledge, the read data, and any memory or load strobe.

Top module: `brd_regdec`

## Requirements
- R1: An access (bus_sel high at a clock edge) is claimed only when bus_addr[23:19] equals base_sw. An unclaimed access produces no acknowledge and no strobe, and changes no register.
- R2: Outside the register window, bus_addr[18:17] gives the memory type, bus_addr[16:15] the tower t and bus_addr[14] the section s. Memory types 0 to 2 drive mem_sel bit type*8 + t*2 + s. Type 3 with bus_addr[14]=0 drives mem_sel bit 24 + t. mem_addr takes bus_addr[13:1], and bus_addr[0] plays no part.
- R3: Memory writes drive a strobe with mem_we=1 only when cmd_func is 2. Memory reads drive a strobe only when cmd_func is 1 or 2. Any other access to memory is acknowledged with no strobe, and a rejected read returns zero.
- R4: A write to the command word (offset 0x64000 in the low 19 bits) loads bus_wdata[23:16] only if bus_wdata[15:0] equals bus_wdata[31:16]. Otherwise it is acknowledged and leaves the register unchanged. The field layout is hi_gain = bit 23, port_sel = bits 22:20, blk_en = bit 19 and cmd_func = bits 18:16.
- R5: A read of the command word returns the stored fields in bits 23:16 and hw_id in bits 7:0, with every other bit zero.
- R6: While cmd_func is 3 or 5, every claimed-base access, at any address, reads or writes the command word under R4 and produces no memory or load strobe.
- R7: Reset (rst_n low at a clock edge) sets cmd_func to 0, port_sel to 7, hi_gain, blk_en, both pedestals and all delays to 0, and clears the acknowledge and all strobes.
- R8: port_oe is high exactly when port_sel differs from 7.
- R9: A write to offset 0x64004 loads ped_lo from bits 27:16 and ped_hi from bits 11:0 and pulses ped_ld. A read of this offset returns zero.
- R10: A write to offset 0x64008 loads channel 0 from bits 5:0 and channel 1 from bits 13:8. A write to 0x6400C loads channel 4 from bits 5:0, channel 5 from 13:8, channel 2 from 21:16 and channel 3 from 29:24. A write to 0x64010 loads channel 6 from bits 21:16 and channel 7 from 29:24. Channel c sits at dly_val[6c+5:6c], and dly_ld bit k pulses for the k-th of these offsets.
- R11: A read of 0x64010 returns adder_mon in bits 8:0. A read of 0x64014 returns twr_tst in bits 21:16. A write to 0x64014 is acknowledged and changes nothing.
- R12: When the card is not locked, offsets 0x64018 to 0x67FFF and type-3 addresses with bus_addr[14]=1 and a nonzero tower are not claimed. Within the register window, bus_addr[1:0] are ignored.
- R13: bus_ack is high for exactly one cycle, in the cycle after each claimed access, including back-to-back accesses. Memory strobes appear only in that same cycle, and for a permitted memory read bus_rdata carries mem_rdata zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_sw | input | 5 | Board number from front-panel switches |
| hw_id | input | 8 | Jumper-set hardware identity |
| bus_sel | input | 1 | Access request, one per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 24 | Access address |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Acknowledge, one cycle after a claimed access |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| mem_sel | output | 28 | One-hot memory select strobe |
| mem_we | output | 1 | Memory write enable, qualifies mem_sel |
| mem_addr | output | 13 | Memory word address |
| mem_rdata | input | 16 | Data returned by the selected memory in the strobe cycle |
| adder_mon | input | 9 | Adder sum monitor value |
| twr_tst | input | 6 | Tower threshold-test monitor value |
| cmd_func | output | 3 | Command function code |
| port_sel | output | 3 | Backplane output port number |
| port_oe | output | 1 | Backplane output enable |
| hi_gain | output | 1 | High gain select |
| blk_en | output | 1 | Overflow blocking enable |
| ped_lo | output | 12 | Low-gain pedestal DAC code |
| ped_hi | output | 12 | High-gain pedestal DAC code |
| ped_ld | output | 1 | Pedestal DAC load pulse |
| dly_val | output | 48 | Eight 6-bit delay settings |
| dly_ld | output | 3 | Delay register load pulses |

## Verification
The hardest state to reach from the ports is the lockout. A write that enters the locked state must itself be a valid command write with matching halves. Once the card is locked, the bench must show two things: a memory address, a pedestal address and an unmapped address all reach the command word, and a write with mismatched halves cannot release the lock. The stimulus enters each of the two locking codes on purpose and sends those accesses before it unlocks. A long random phase then mixes valid, corrupted and foreign-base command writes with memory and register traffic, so that the card moves through all eight function codes while a behavioural model follows every cycle.

// File: rtl/brd_pkg.sv
// Package: shared types for the trigger card register decoder.
// Assumes one access per cycle; the target code is recomputed every cycle.
package brd_pkg;

    // Function codes held in the command word
    typedef enum logic [2:0] {
        FN_IDLE    = 3'd0,
        FN_RDONLY  = 3'd1,
        FN_RDWR    = 3'd2,
        FN_FAKE    = 3'd3,
        FN_RSV4    = 3'd4,
        FN_CLEAR   = 3'd5,
        FN_RSV6    = 3'd6,
        FN_RSV7    = 3'd7
    } cmd_fn_e;

    // Where a claimed access goes
    typedef enum logic [2:0] {
        TG_NONE = 3'd0,
        TG_MEM  = 3'd1,
        TG_CMD  = 3'd2,
        TG_PED  = 3'd3,
        TG_DLYA = 3'd4,
        TG_DLYB = 3'd5,
        TG_DLYC = 3'd6,
        TG_MON  = 3'd7
    } tgt_e;

    // True when a function code locks all accesses onto the command word
    function automatic logic fn_locks(input logic [2:0] fn);
        return (fn == FN_FAKE) || (fn == FN_CLEAR);
    endfunction

endpackage

// File: rtl/brd_addr_dec.sv
// Module: brd_addr_dec
// Purely combinational address decoder. It compares the board field with the
// switches, then picks a memory block or a control register. When the lock
// input is high, every matching address is sent to the command word.
// Assumes the field layout: base | type(2) | tower | section(1) | word | byte(1).
module brd_addr_dec
    import brd_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int BASE_W = 5,
    parameter int WORD_W = 13,
    parameter int TOWERS = 4,
    parameter int MIDX_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BASE_W-1:0] base,
    input  logic              lock,
    output logic              hit,
    output tgt_e              tgt,
    output logic [MIDX_W-1:0] midx,
    output logic [WORD_W-1:0] word
);
    localparam int TWR_W  = $clog2(TOWERS);
    localparam int SEC_B  = WORD_W + 1;
    localparam int TWR_L  = SEC_B + 1;
    localparam int TYP_L  = TWR_L + TWR_W;
    localparam int ROFF_W = WORD_W - 1;

    logic              base_ok;
    logic [1:0]        mtype;
    logic [TWR_W-1:0]  twr;
    logic              sec;
    logic [ROFF_W-1:0] roff;
    logic              unused_lsb;

    assign unused_lsb = addr[0];

    // Split the address into its fields
    always_comb begin
        base_ok = (addr[ADDR_W-1 -: BASE_W] == base);
        mtype   = addr[TYP_L +: 2];
        twr     = addr[TWR_L +: TWR_W];
        sec     = addr[SEC_B];
        roff    = addr[WORD_W:2];
        word    = addr[WORD_W:1];
    end

    // Choose the target of the access
    always_comb begin
        hit  = 1'b0;
        tgt  = TG_NONE;
        midx = '0;
        if (base_ok) begin
            if (lock) begin
                hit = 1'b1;
                tgt = TG_CMD;
            end else if (mtype != 2'd3) begin
                hit  = 1'b1;
                tgt  = TG_MEM;
                midx = MIDX_W'(int'(mtype) * 2 * TOWERS + int'(twr) * 2 + int'(sec));
            end else if (!sec) begin
                hit  = 1'b1;
                tgt  = TG_MEM;
                midx = MIDX_W'(6 * TOWERS + int'(twr));
            end else if (twr == '0) begin
                hit = 1'b1;
                case (roff)
                    ROFF_W'(0): tgt = TG_CMD;
                    ROFF_W'(1): tgt = TG_PED;
                    ROFF_W'(2): tgt = TG_DLYA;
                    ROFF_W'(3): tgt = TG_DLYB;
                    ROFF_W'(4): tgt = TG_DLYC;
                    ROFF_W'(5): tgt = TG_MON;
                    default: begin
                        hit = 1'b0;
                        tgt = TG_NONE;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/brd_cmd_reg.sv
// Module: brd_cmd_reg
// Holds the 8-bit command field. A write loads only when the two 16-bit
// halves of the data agree. Reset leaves the output port disabled.
// Assumes wr_en is high for one cycle per accepted bus write.
module brd_cmd_reg
    import brd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [7:0]        cmd_q,
    output logic              lock
);
    localparam int HALF_W = DATA_W / 2;
    localparam logic [7:0] RST_VAL = {1'b0, 3'd7, 1'b0, FN_IDLE};

    logic halves_ok;

    // Integrity check on the write data
    assign halves_ok = (wdata[HALF_W-1:0] == wdata[DATA_W-1:HALF_W]);

    // Command field storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= RST_VAL;
        end else if (wr_en && halves_ok) begin
            cmd_q <= wdata[HALF_W +: 8];
        end
    end

    // Lockout flag from the stored function code
    assign lock = fn_locks(cmd_q[2:0]);

endmodule

// File: rtl/brd_cfg_regs.sv
// Module: brd_cfg_regs
// Write-only settings: two pedestal DAC codes and eight delay channels spread
// over three registers. Each channel's register and lane come from its index.
// Assumes each write enable is high for at most one cycle per access.
module brd_cfg_regs #(
    parameter int DATA_W = 32,
    parameter int DAC_W  = 12,
    parameter int DLY_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ped_wr,
    input  logic [2:0]        dly_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DAC_W-1:0]  ped_lo,
    output logic [DAC_W-1:0]  ped_hi,
    output logic [8*DLY_W-1:0] dly_flat
);
    localparam int DLY_CH = 8;
    localparam int LANE_W = 8;
    localparam int HALF_W = DATA_W / 2;

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    // Pedestal DAC codes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ped_lo <= '0;
            ped_hi <= '0;
        end else if (ped_wr) begin
            ped_lo <= wdata[HALF_W +: DAC_W];
            ped_hi <= wdata[0 +: DAC_W];
        end
    end

    for (genvar c = 0; c < DLY_CH; c++) begin : g_ch
        localparam int RG = (c < 2) ? 0 : ((c < 6) ? 1 : 2);
        localparam int LN = c % 4;
        logic [DLY_W-1:0] q;

        // One delay channel, loaded from its own lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (dly_wr[RG]) begin
                q <= wdata[LN*LANE_W +: DLY_W];
            end
        end

        assign dly_flat[c*DLY_W +: DLY_W] = q;
    end

endmodule

// File: rtl/brd_regdec.sv
// Module: brd_regdec (top)
// Bus slave decoder and control register bank for a trigger card. Accesses
// are single-cycle requests; the response (ack, read data, strobes) is
// registered and appears one cycle later. The memory answers in the strobe
// cycle, so its data goes to bus_rdata combinationally in that cycle.
module brd_regdec
    import brd_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int BASE_W  = 5,
    parameter int DATA_W  = 32,
    parameter int ID_W    = 8,
    parameter int WORD_W  = 13,
    parameter int TOWERS  = 4,
    parameter int MEM_DW  = 16,
    parameter int DAC_W   = 12,
    parameter int DLY_W   = 6,
    parameter int ADDER_W = 9,
    parameter int TTST_W  = 6,
    localparam int NMEM   = 7 * TOWERS,
    localparam int DLYV_W = 8 * DLY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BASE_W-1:0] base_sw,
    input  logic [ID_W-1:0]   hw_id,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NMEM-1:0]   mem_sel,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    input  logic [MEM_DW-1:0] mem_rdata,
    input  logic [ADDER_W-1:0] adder_mon,
    input  logic [TTST_W-1:0] twr_tst,
    output logic [2:0]        cmd_func,
    output logic [2:0]        port_sel,
    output logic              port_oe,
    output logic              hi_gain,
    output logic              blk_en,
    output logic [DAC_W-1:0]  ped_lo,
    output logic [DAC_W-1:0]  ped_hi,
    output logic              ped_ld,
    output logic [DLYV_W-1:0] dly_val,
    output logic [2:0]        dly_ld
);
    localparam int MIDX_W = $clog2(NMEM);
    localparam int HALF_W = DATA_W / 2;
    localparam int TTST_L = HALF_W;

    logic              dec_hit;
    tgt_e              dec_tgt;
    logic [MIDX_W-1:0] dec_midx;
    logic [WORD_W-1:0] dec_word;
    logic [7:0]        cmd_q;
    logic              lock;
    logic              acc;
    logic              mem_ok;
    logic              cmd_wr;
    logic              ped_wr;
    logic [2:0]        dly_wr;
    logic [DATA_W-1:0] reg_rd;
    logic              ack_q;
    logic              memrd_q;
    logic [DATA_W-1:0] rdata_q;
    logic [NMEM-1:0]   sel_q;
    logic              we_q;
    logic [WORD_W-1:0] maddr_q;
    logic              ped_ld_q;
    logic [2:0]        dly_ld_q;

    brd_addr_dec #(
        .ADDR_W (ADDR_W),
        .BASE_W (BASE_W),
        .WORD_W (WORD_W),
        .TOWERS (TOWERS),
        .MIDX_W (MIDX_W)
    ) dec_i (
        .addr (bus_addr),
        .base (base_sw),
        .lock (lock),
        .hit  (dec_hit),
        .tgt  (dec_tgt),
        .midx (dec_midx),
        .word (dec_word)
    );

    brd_cmd_reg #(
        .DATA_W (DATA_W)
    ) cmd_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cmd_wr),
        .wdata (bus_wdata),
        .cmd_q (cmd_q),
        .lock  (lock)
    );

    brd_cfg_regs #(
        .DATA_W (DATA_W),
        .DAC_W  (DAC_W),
        .DLY_W  (DLY_W)
    ) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ped_wr   (ped_wr),
        .dly_wr   (dly_wr),
        .wdata    (bus_wdata),
        .ped_lo   (ped_lo),
        .ped_hi   (ped_hi),
        .dly_flat (dly_val)
    );

    // Access qualification and per-target write enables
    always_comb begin
        acc    = bus_sel && dec_hit;
        mem_ok = (dec_tgt == TG_MEM) &&
                 (bus_wr ? (cmd_q[2:0] == FN_RDWR)
                         : (cmd_q[2:0] == FN_RDWR || cmd_q[2:0] == FN_RDONLY));
        cmd_wr = acc && bus_wr && (dec_tgt == TG_CMD);
        ped_wr = acc && bus_wr && (dec_tgt == TG_PED);
        dly_wr = {acc && bus_wr && (dec_tgt == TG_DLYC),
                  acc && bus_wr && (dec_tgt == TG_DLYB),
                  acc && bus_wr && (dec_tgt == TG_DLYA)};
    end

    // Register read-back selection
    always_comb begin
        reg_rd = '0;
        case (dec_tgt)
            TG_CMD:  begin
                reg_rd[HALF_W +: 8] = cmd_q;
                reg_rd[ID_W-1:0]    = hw_id;
            end
            TG_DLYC: reg_rd[ADDER_W-1:0]        = adder_mon;
            TG_MON:  reg_rd[TTST_L +: TTST_W]   = twr_tst;
            default: reg_rd = '0;
        endcase
    end

    // Registered response and strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q    <= 1'b0;
            memrd_q  <= 1'b0;
            rdata_q  <= '0;
            sel_q    <= '0;
            we_q     <= 1'b0;
            maddr_q  <= '0;
            ped_ld_q <= 1'b0;
            dly_ld_q <= '0;
        end else begin
            ack_q    <= acc;
            memrd_q  <= acc && mem_ok && !bus_wr;
            rdata_q  <= (acc && !bus_wr && dec_tgt != TG_MEM) ? reg_rd : '0;
            sel_q    <= (acc && mem_ok) ? (NMEM'(1) << dec_midx) : '0;
            we_q     <= acc && mem_ok && bus_wr;
            ped_ld_q <= ped_wr;
            dly_ld_q <= dly_wr;
            if (acc) begin
                maddr_q <= dec_word;
            end
        end
    end

    // Output assembly
    always_comb begin
        bus_ack   = ack_q;
        bus_rdata = memrd_q ? DATA_W'(mem_rdata) : rdata_q;
        mem_sel   = sel_q;
        mem_we    = we_q;
        mem_addr  = maddr_q;
        ped_ld    = ped_ld_q;
        dly_ld    = dly_ld_q;
        cmd_func  = cmd_q[2:0];
        blk_en    = cmd_q[3];
        port_sel  = cmd_q[6:4];
        hi_gain   = cmd_q[7];
        port_oe   = (cmd_q[6:4] != 3'd7);
    end

endmodule

// File: rtl/brd_regdec_chk.sv
// Module: brd_regdec_chk
// Property checker for brd_regdec, attached by bind. It only observes ports.
module brd_regdec_chk #(
    parameter int ADDR_W = 24,
    parameter int BASE_W = 5,
    parameter int DATA_W = 32,
    parameter int NMEM   = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BASE_W-1:0] base_sw,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ack,
    input logic [NMEM-1:0]   mem_sel,
    input logic              mem_we,
    input logic [2:0]        cmd_func,
    input logic [2:0]        port_sel,
    input logic              hi_gain,
    input logic              blk_en
);
    localparam int HALF_W = DATA_W / 2;

    // R1
    foreign_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && (bus_addr[ADDR_W-1 -: BASE_W] != base_sw)) |=> !bus_ack);

    // R13
    ack_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(bus_sel));

    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_sel));

    // R3
    mem_write_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && (mem_sel != '0)) |-> ($past(cmd_func) == 3'd2));

    // R6
    lock_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && (cmd_func == 3'd3 || cmd_func == 3'd5)) |=> (mem_sel == '0));

    // R4
    cmd_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({hi_gain, port_sel, blk_en, cmd_func}) |->
            $past(bus_sel && bus_wr &&
                  (bus_wdata[HALF_W-1:0] == bus_wdata[DATA_W-1:HALF_W])));

    // R13
    strobe_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_sel != '0) |-> bus_ack);

endmodule

bind brd_regdec brd_regdec_chk #(
    .ADDR_W (ADDR_W),
    .BASE_W (BASE_W),
    .DATA_W (DATA_W),
    .NMEM   (NMEM)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_sw   (base_sw),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .mem_sel   (mem_sel),
    .mem_we    (mem_we),
    .cmd_func  (cmd_func),
    .port_sel  (port_sel),
    .hi_gain   (hi_gain),
    .blk_en    (blk_en)
);

// File: tb/brd_regdec_tb_top.sv
// Bench for brd_regdec: a behavioural model updated at each rising edge and
// compared with every output at each falling edge.
module brd_regdec_tb_top;
    localparam logic [4:0] SW = 5'h0B;
    localparam logic [7:0] HWID = 8'hA5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_sel = 1'b0;
    logic        b_wr = 1'b0;
    logic [23:0] b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic [8:0]  adder = 9'h15A;
    logic [5:0]  ttst = 6'h2D;

    logic        bus_ack;
    logic [31:0] bus_rdata;
    logic [27:0] mem_sel;
    logic        mem_we;
    logic [12:0] mem_addr;
    logic [15:0] mem_rdata;
    logic [2:0]  cmd_func;
    logic [2:0]  port_sel;
    logic        port_oe;
    logic        hi_gain;
    logic        blk_en;
    logic [11:0] ped_lo;
    logic [11:0] ped_hi;
    logic        ped_ld;
    logic [47:0] dly_val;
    logic [2:0]  dly_ld;

    int total = 0;
    int bad = 0;
    bit running = 0;
    bit finished = 0;
    string phase = "R7";

    always #5 clk = ~clk;

    assign mem_rdata = {3'b101, mem_addr};

    brd_regdec dut_i (
        .clk(clk), .rst_n(rst_n), .base_sw(SW), .hw_id(HWID),
        .bus_sel(b_sel), .bus_wr(b_wr), .bus_addr(b_addr), .bus_wdata(b_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .mem_sel(mem_sel),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .adder_mon(adder), .twr_tst(ttst), .cmd_func(cmd_func),
        .port_sel(port_sel), .port_oe(port_oe), .hi_gain(hi_gain),
        .blk_en(blk_en), .ped_lo(ped_lo), .ped_hi(ped_hi), .ped_ld(ped_ld),
        .dly_val(dly_val), .dly_ld(dly_ld)
    );

    // ---------------- reference model ----------------
    logic [2:0]  m_fn, m_port;
    logic        m_gain, m_blk;
    logic [11:0] m_plo, m_phi;
    logic [5:0]  m_dly [8];
    logic        e_ack, e_we, e_pedld;
    logic [2:0]  e_dlyld;
    logic [27:0] e_sel;
    logic [31:0] e_rdata;
    int          off, idx, kind;
    bit          locked, permit;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_fn = 3'd0; m_port = 3'd7; m_gain = 0; m_blk = 0;
            m_plo = '0; m_phi = '0;
            for (int i = 0; i < 8; i++) m_dly[i] = '0;
            e_ack = 0; e_we = 0; e_pedld = 0; e_dlyld = '0; e_sel = '0; e_rdata = '0;
        end else begin
            e_ack = 0; e_we = 0; e_pedld = 0; e_dlyld = '0; e_sel = '0; e_rdata = '0;
            kind = 0;
            idx = 0;
            if (b_sel && (b_addr[23:19] == SW)) begin
                off = int'(b_addr) & 'h7FFFF;
                locked = (m_fn == 3'd3) || (m_fn == 3'd5);
                if (locked) kind = 10;
                else if (off < 'h60000) begin
                    kind = 1;
                    idx = (off >> 17) * 8 + ((off >> 15) & 3) * 2 + ((off >> 14) & 1);
                end else if ((off & 'h4000) == 0) begin
                    kind = 1;
                    idx = 24 + ((off >> 15) & 3);
                end else if (off >= 'h64000 && off < 'h64018) begin
                    kind = 10 + ((off - 'h64000) >> 2);
                end
                if (kind != 0) begin
                    e_ack = 1;
                    if (kind == 1) begin
                        permit = b_wr ? (m_fn == 3'd2) : (m_fn == 3'd1 || m_fn == 3'd2);
                        if (permit) begin
                            e_sel[idx] = 1'b1;
                            e_we = b_wr;
                            if (!b_wr) e_rdata = {16'h0, 3'b101, 13'((off >> 1) & 'h1FFF)};
                        end
                    end else if (!b_wr) begin
                        if (kind == 10) e_rdata = {8'h0, m_gain, m_port, m_blk, m_fn, 8'h0, HWID};
                        if (kind == 14) e_rdata = {23'h0, adder};
                        if (kind == 15) e_rdata = {10'h0, ttst, 16'h0};
                    end else begin
                        case (kind)
                            10: if (b_wdata[15:0] == b_wdata[31:16]) begin
                                    m_gain = b_wdata[23]; m_port = b_wdata[22:20];
                                    m_blk = b_wdata[19]; m_fn = b_wdata[18:16];
                                end
                            11: begin
                                    m_plo = b_wdata[27:16]; m_phi = b_wdata[11:0]; e_pedld = 1;
                                end
                            12: begin
                                    m_dly[0] = b_wdata[5:0]; m_dly[1] = b_wdata[13:8]; e_dlyld[0] = 1;
                                end
                            13: begin
                                    m_dly[4] = b_wdata[5:0]; m_dly[5] = b_wdata[13:8];
                                    m_dly[2] = b_wdata[21:16]; m_dly[3] = b_wdata[29:24];
                                    e_dlyld[1] = 1;
                                end
                            14: begin
                                    m_dly[6] = b_wdata[21:16]; m_dly[7] = b_wdata[29:24]; e_dlyld[2] = 1;
                                end
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string rq, input string nm, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s (phase %s) %s act=%h exp=%h", rq, phase, nm, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (running) begin
            chk("R13", "bus_ack", 64'(bus_ack), 64'(e_ack));
            if (e_ack) chk("R5", "bus_rdata", 64'(bus_rdata), 64'(e_rdata));
            chk("R2", "mem_sel", 64'(mem_sel), 64'(e_sel));
            if (e_sel != '0) chk("R3", "mem_we", 64'(mem_we), 64'(e_we));
            chk("R4", "cmd_fields", 64'({hi_gain, port_sel, blk_en, cmd_func}),
                64'({m_gain, m_port, m_blk, m_fn}));
            chk("R8", "port_oe", 64'(port_oe), 64'(m_port != 3'd7));
            chk("R9", "ped", 64'({ped_ld, ped_lo, ped_hi}), 64'({e_pedld, m_plo, m_phi}));
            chk("R10", "dly_val", 64'(dly_val),
                64'({m_dly[7], m_dly[6], m_dly[5], m_dly[4], m_dly[3], m_dly[2], m_dly[1], m_dly[0]}));
            chk("R10", "dly_ld", 64'(dly_ld), 64'(e_dlyld));
        end
    end

    // ---------------- stimulus ----------------
    localparam logic [23:0] BASE = {SW, 19'h0};

    task automatic acc(input bit wr, input logic [23:0] a, input logic [31:0] d);
        @(negedge clk);
        b_sel = 1'b1; b_wr = wr; b_addr = a; b_wdata = d;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            b_sel = 1'b0;
        end
    endtask

    function automatic logic [31:0] cmdw(input logic [7:0] v);
        return {8'h0, v, 8'h0, v};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        running = 1;
        @(negedge clk);
        // R7: reset state seen at the ports
        chk("R7", "port_oe_reset", 64'(port_oe), 64'(0));
        chk("R7", "port_sel_reset", 64'(port_sel), 64'(7));
        chk("R7", "cmd_func_reset", 64'(cmd_func), 64'(0));
        rst_n = 1'b1;
        idle(1);

        phase = "R1";
        acc(1, {5'h0C, 19'h64000}, cmdw(8'h22));
        acc(0, {5'h0A, 19'h00000}, 0);
        acc(1, {5'h1B, 19'h64004}, 32'h0ABC_0DEF);
        idle(2);

        phase = "R3";
        acc(0, BASE | 24'h0_2468, 0);
        acc(1, BASE | 24'h0_4002, 32'h1234);
        idle(1);

        phase = "R4";
        acc(1, BASE | 24'h64000, 32'h0022_0021);
        acc(1, BASE | 24'h64000, 32'h00A2_00A3);
        acc(1, BASE | 24'h64000, cmdw(8'hB2));
        idle(1);

        phase = "R5";
        acc(0, BASE | 24'h64000, 0);
        acc(0, BASE | 24'h64002, 0);
        idle(1);

        phase = "R2";
        for (int t = 0; t < 3; t++)
            for (int tw = 0; tw < 4; tw++)
                for (int s = 0; s < 2; s++)
                    acc((tw + s) % 2 == 1, BASE | 24'(t << 17) | 24'(tw << 15) | 24'(s << 14) | 24'(tw * 77 + s),
                        32'(t * 16 + tw));
        for (int tw = 0; tw < 4; tw++) acc(0, BASE | 24'h60000 | 24'(tw << 15) | 24'h3FFF, 0);
        idle(1);

        phase = "R3";
        acc(1, BASE | 24'h64000, cmdw(8'h01));
        acc(1, BASE | 24'h2_0010, 32'h55);
        acc(0, BASE | 24'h2_0010, 0);
        acc(1, BASE | 24'h64000, cmdw(8'h04));
        acc(0, BASE | 24'h1_2000, 0);
        acc(1, BASE | 24'h64000, cmdw(8'h00));
        acc(0, BASE | 24'h6_8000, 0);
        idle(1);

        phase = "R9";
        acc(1, BASE | 24'h64004, 32'hFBE8_7418);
        acc(0, BASE | 24'h64004, 0);
        idle(1);

        phase = "R10";
        acc(1, BASE | 24'h64008, 32'hFFFF_2A15);
        acc(1, BASE | 24'h6400C, 32'h3F21_0C33);
        acc(1, BASE | 24'h64010, 32'h1122_0007);
        acc(0, BASE | 24'h64008, 0);
        idle(1);

        phase = "R11";
        acc(0, BASE | 24'h64010, 0);
        acc(0, BASE | 24'h64014, 0);
        acc(1, BASE | 24'h64014, 32'hFFFF_FFFF);
        adder = 9'h0A3; ttst = 6'h12;
        acc(0, BASE | 24'h64011, 0);
        acc(0, BASE | 24'h64017, 0);
        idle(1);

        phase = "R12";
        acc(0, BASE | 24'h64018, 0);
        acc(1, BASE | 24'h64020, cmdw(8'h02));
        acc(0, BASE | 24'h6C000, 0);
        acc(1, BASE | 24'h7C004, cmdw(8'h02));
        acc(0, BASE | 24'h67FFC, 0);
        idle(1);

        phase = "R8";
        for (int p = 0; p < 8; p++) acc(1, BASE | 24'h64000, cmdw(8'(p << 4) | 8'h88 & 8'h8F | 8'h02));
        idle(1);

        phase = "R6";
        acc(1, BASE | 24'h64000, cmdw(8'h33));
        acc(0, BASE | 24'h0_8000, 0);
        acc(1, BASE | 24'h64004, 32'h0123_0456);
        acc(0, BASE | 24'h7C000, 0);
        acc(1, BASE | 24'h0_0000, 32'h0002_0003);
        acc(1, {5'h01, 19'h64000}, cmdw(8'h02));
        acc(1, BASE | 24'h64008, cmdw(8'h55));
        acc(0, BASE | 24'h3_0000, 0);
        acc(1, BASE | 24'h5_0000, cmdw(8'h02));
        acc(1, BASE | 24'h64004, 32'h0123_0456);
        idle(1);

        phase = "R13";
        for (int i = 0; i < 400; i++) begin
            int cat;
            cat = int'($urandom % 7);
            case (cat)
                0: acc($urandom % 2 == 1, BASE | 24'($urandom % 'h60000), $urandom);
                1: acc($urandom % 2 == 1, BASE | 24'h64000 | 24'($urandom % 'h20), $urandom);
                2: acc(1, BASE | 24'h64000, cmdw(8'($urandom) & 8'hF8 | 8'($urandom % 3)));
                3: acc(1, BASE | 24'h64000, cmdw(8'($urandom)));
                4: acc($urandom % 2 == 1, {5'($urandom) ^ 5'h10, 19'($urandom)}, $urandom);
                5: acc($urandom % 2 == 1, BASE | 24'h60000 | 24'($urandom % 'h20000), $urandom);
                default: idle(1);
            endcase
        end
        idle(3);

        running = 0;
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog (phase %s) run act=hung exp=finished", phase);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule